// File: doc/BRIEF.md
# Repeat-Loop Exception Acceptance Gate

This block sits beside the instruction issue stage of a core that runs zero-overhead hardware repeat loops. In every issue slot it decides whether a pending exception may be taken in front of the instruction about to execute. The decision depends on two things: the kind of exception, and where that instruction sits inside the loop. Requests that may not be taken yet are latched. They are taken in front of a later instruction that is allowed to take them, and the return address saved is that later instruction's address.

Each issue slot carries three pieces of information. The first is a position tag: ordinary, the instruction two before the loop end ("near-end"), or the loop-end instruction. The second is the instruction's address. The third is the repeat count. When the repeat count is zero, every slot is treated as ordinary. Five raw request lines feed the gate. A CPU address error also carries two flags: whether it happened in the repeat-control window, and whether it was a data access. One cycle after a slot in which a request is taken, the gate pulses an accept strobe. In that same cycle it presents the exception type, the event code and the saved PC.

Top module: `rpt_exc_gate`

## Requirements
- R1: After reset `accept_o` is 0 and no request is pending.
- R2: At an ordinary slot (pos 0, or pos 3, or repeat count 0), the highest-priority eligible request is taken. The priority order, with the `exc_type_o` codes, is: CPU address error (1), DMA address error (2), user break before execution (3), interrupt (4), user break after execution (5). `accept_o` rises in the cycle after the slot, and `saved_pc_o` equals that slot's `pc_i`.
- R3: At a near-end slot (pos 1, repeat count nonzero), only a CPU address error or a user break before execution can be taken. The saved PC is the near-end instruction's address.
- R4: At a loop-end slot (pos 2, repeat count nonzero), only a CPU address error can be taken.
- R5: With a repeat count of 0, pos 1 and pos 2 slots behave exactly as ordinary slots.
- R6: A request that is not taken stays pending even after its raw line drops. It is taken at the next slot that allows it, and the saved PC is that slot's address.
- R7: Taking a request clears only that request's pending state. Other pending requests remain, and are taken one per slot in priority order.
- R8: The event code of a CPU address error depends on its flags. If it occurred in the repeat-control window, the code is 0x070. Otherwise it is 0x100 for a data access or 0x0E0 for an instruction access.
- R9: Other event codes: DMA address error 0x5C0, both user breaks 0x1E0, interrupt 0x200.
- R10: No acceptance happens in a cycle without a valid slot. A request raised while `slot_valid_i` is 0 is latched, and is taken at the next eligible slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot_valid_i | input | 1 | An instruction issues this cycle |
| pos_i | input | 2 | Loop position: 0 ordinary, 1 near-end, 2 loop-end, 3 ordinary |
| pc_i | input | 32 | Address of the issuing instruction |
| rpt_cnt_i | input | 12 | Remaining repeat count |
| req_irq_i | input | 1 | Interrupt request |
| req_dma_ae_i | input | 1 | DMA address error request |
| req_ubrk_pre_i | input | 1 | User break before execution request |
| req_ubrk_post_i | input | 1 | User break after execution request |
| req_cpu_ae_i | input | 1 | CPU address error request |
| ae_in_rpt_i | input | 1 | CPU address error lies in the repeat-control window |
| ae_is_data_i | input | 1 | CPU address error is a data access |
| accept_o | output | 1 | One-cycle accept pulse |
| exc_type_o | output | 3 | Type of the accepted exception (R2 encoding) |
| evt_code_o | output | 12 | Event code of the accepted exception |
| saved_pc_o | output | 32 | Return address saved for the accepted exception |

## Verification
Every result is registered once. The accept strobe, type, code and saved PC for a slot sampled at one rising edge are all valid together in the following cycle. Pending state is updated at that same edge, so it first affects the slot after. The bench drives each slot at a falling edge and checks the outputs at the next falling edge. Between those two edges it advances its own model of the pending requests, so every comparison falls one register after its stimulus.

// File: rtl/rpt_exc_pkg.sv
package rpt_exc_pkg;
  localparam int unsigned N_EXC = 5;

  // bit index in request vectors == priority rank (0 highest)
  localparam int unsigned IX_CPU_AE    = 0;
  localparam int unsigned IX_DMA_AE    = 1;
  localparam int unsigned IX_UBRK_PRE  = 2;
  localparam int unsigned IX_IRQ       = 3;
  localparam int unsigned IX_UBRK_POST = 4;

  typedef enum logic [1:0] {
    POS_ORD = 2'd0,
    POS_NEAR = 2'd1,
    POS_END = 2'd2,
    POS_RSV = 2'd3
  } pos_e;

  typedef enum logic [2:0] {
    EXC_NONE      = 3'd0,
    EXC_CPU_AE    = 3'd1,
    EXC_DMA_AE    = 3'd2,
    EXC_UBRK_PRE  = 3'd3,
    EXC_IRQ       = 3'd4,
    EXC_UBRK_POST = 3'd5
  } exc_e;
endpackage

// File: rtl/rpt_pos_qual.sv
module rpt_pos_qual
  import rpt_exc_pkg::*;
#(
  parameter int unsigned RCW = 12
) (
  input  logic [1:0]       pos_i,
  input  logic [RCW-1:0]   rpt_cnt_i,
  output logic [N_EXC-1:0] elig_o
);
  pos_e eff_pos;

  always_comb begin
    if (rpt_cnt_i == '0) eff_pos = POS_ORD;
    else begin
      unique case (pos_i)
        2'd1:    eff_pos = POS_NEAR;
        2'd2:    eff_pos = POS_END;
        default: eff_pos = POS_ORD;
      endcase
    end
  end

  for (genvar g = 0; g < N_EXC; g++) begin : g_elig
    always_comb begin
      unique case (eff_pos)
        POS_NEAR: elig_o[g] = (g == IX_CPU_AE) || (g == IX_UBRK_PRE);
        POS_END:  elig_o[g] = (g == IX_CPU_AE);
        default:  elig_o[g] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/rpt_pend_store.sv
module rpt_pend_store
  import rpt_exc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXC-1:0] raw_i,
  input  logic [N_EXC-1:0] grant_i,
  input  logic             ae_in_rpt_i,
  input  logic             ae_is_data_i,
  output logic [N_EXC-1:0] pend_o,
  output logic             eff_ae_rpt_o,
  output logic             eff_ae_data_o
);
  logic [N_EXC-1:0] pend_q;
  logic             ae_rpt_q, ae_data_q;

  for (genvar g = 0; g < N_EXC; g++) begin : g_pend
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[g] <= 1'b0;
      else         pend_q[g] <= (pend_q[g] | raw_i[g]) & ~grant_i[g];
    end

    a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[g] && !grant_i[g]) |=> pend_q[g]);
    a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_i[g] && !raw_i[g]) |=> !pend_q[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_rpt_q  <= 1'b0;
      ae_data_q <= 1'b0;
    end else if (raw_i[IX_CPU_AE]) begin
      ae_rpt_q  <= ae_in_rpt_i;
      ae_data_q <= ae_is_data_i;
    end
  end

  assign pend_o        = pend_q;
  assign eff_ae_rpt_o  = raw_i[IX_CPU_AE] ? ae_in_rpt_i  : ae_rpt_q;
  assign eff_ae_data_o = raw_i[IX_CPU_AE] ? ae_is_data_i : ae_data_q;
endmodule

// File: rtl/rpt_prio_sel.sv
module rpt_prio_sel #(
  parameter int unsigned N  = 5,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IW'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/rpt_exc_gate.sv
module rpt_exc_gate
  import rpt_exc_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned RCW         = 12,
  parameter int unsigned CW          = 12,
  parameter logic [CW-1:0] CODE_RPT_AE = 12'h070,
  parameter logic [CW-1:0] CODE_IAE    = 12'h0E0,
  parameter logic [CW-1:0] CODE_DAE    = 12'h100,
  parameter logic [CW-1:0] CODE_DMA_AE = 12'h5C0,
  parameter logic [CW-1:0] CODE_UBRK   = 12'h1E0,
  parameter logic [CW-1:0] CODE_IRQ    = 12'h200
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           slot_valid_i,
  input  logic [1:0]     pos_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [RCW-1:0] rpt_cnt_i,
  input  logic           req_irq_i,
  input  logic           req_dma_ae_i,
  input  logic           req_ubrk_pre_i,
  input  logic           req_ubrk_post_i,
  input  logic           req_cpu_ae_i,
  input  logic           ae_in_rpt_i,
  input  logic           ae_is_data_i,
  output logic           accept_o,
  output logic [2:0]     exc_type_o,
  output logic [CW-1:0]  evt_code_o,
  output logic [AW-1:0]  saved_pc_o
);
  localparam int unsigned IW = $clog2(N_EXC);

  logic [N_EXC-1:0] raw, elig, pend, cand, grant;
  logic [IW-1:0]    sel_idx;
  logic             sel_any, eff_ae_rpt, eff_ae_data;
  logic [CW-1:0]    code_d;

  always_comb begin
    raw               = '0;
    raw[IX_CPU_AE]    = req_cpu_ae_i;
    raw[IX_DMA_AE]    = req_dma_ae_i;
    raw[IX_UBRK_PRE]  = req_ubrk_pre_i;
    raw[IX_IRQ]       = req_irq_i;
    raw[IX_UBRK_POST] = req_ubrk_post_i;
  end

  rpt_pos_qual #(.RCW(RCW)) i_pos_qual (
    .pos_i    (pos_i),
    .rpt_cnt_i(rpt_cnt_i),
    .elig_o   (elig)
  );

  rpt_pend_store i_pend_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .raw_i        (raw),
    .grant_i      (grant),
    .ae_in_rpt_i  (ae_in_rpt_i),
    .ae_is_data_i (ae_is_data_i),
    .pend_o       (pend),
    .eff_ae_rpt_o (eff_ae_rpt),
    .eff_ae_data_o(eff_ae_data)
  );

  assign cand = (pend | raw) & elig & {N_EXC{slot_valid_i}};

  rpt_prio_sel #(.N(N_EXC)) i_prio_sel (
    .req_i  (cand),
    .grant_o(grant),
    .idx_o  (sel_idx),
    .any_o  (sel_any)
  );

  always_comb begin
    unique case (sel_idx)
      IW'(IX_CPU_AE):   code_d = eff_ae_rpt  ? CODE_RPT_AE :
                                 eff_ae_data ? CODE_DAE : CODE_IAE;
      IW'(IX_DMA_AE):   code_d = CODE_DMA_AE;
      IW'(IX_IRQ):      code_d = CODE_IRQ;
      default:          code_d = CODE_UBRK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o   <= 1'b0;
      exc_type_o <= EXC_NONE;
      evt_code_o <= '0;
      saved_pc_o <= '0;
    end else begin
      accept_o <= sel_any;
      if (sel_any) begin
        exc_type_o <= 3'(sel_idx) + 3'd1;
        evt_code_o <= code_d;
        saved_pc_o <= pc_i;
      end
    end
  end

  a_r10_slot_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(slot_valid_i));
  a_r2_type_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (exc_type_o inside {[3'd1:3'd5]}));
  a_r3_near_filter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_valid_i && pos_i == 2'd1 && rpt_cnt_i != '0) |=>
      (!accept_o || exc_type_o == EXC_CPU_AE || exc_type_o == EXC_UBRK_PRE));
  a_r4_end_filter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_valid_i && pos_i == 2'd2 && rpt_cnt_i != '0) |=>
      (!accept_o || exc_type_o == EXC_CPU_AE));
  a_r8_rpt_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_valid_i && req_cpu_ae_i && ae_in_rpt_i) |=>
      (accept_o && exc_type_o == EXC_CPU_AE && evt_code_o == CODE_RPT_AE));
endmodule

// File: tb/test_rpt_exc_gate.sv
module test_rpt_exc_gate;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        slot_valid_i = 1'b0;
  logic [1:0]  pos_i = '0;
  logic [31:0] pc_i = '0;
  logic [11:0] rpt_cnt_i = '0;
  logic        req_irq_i = 0, req_dma_ae_i = 0, req_ubrk_pre_i = 0;
  logic        req_ubrk_post_i = 0, req_cpu_ae_i = 0;
  logic        ae_in_rpt_i = 0, ae_is_data_i = 0;
  logic        accept_o;
  logic [2:0]  exc_type_o;
  logic [11:0] evt_code_o;
  logic [31:0] saved_pc_o;

  int n_chk = 0, n_fail = 0;
  logic [4:0] m_pend = '0;
  logic       m_rpt = 0, m_data = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rpt_exc_gate i_rpt_exc_gate (.*);

  function automatic logic [4:0] elig_of(logic [1:0] p, logic [11:0] rc);
    if (rc == 0 || p == 2'd0 || p == 2'd3) return 5'b11111;
    if (p == 2'd1) return 5'b00101;
    return 5'b00001;
  endfunction

  function automatic logic [11:0] code_of(int ix, logic rpt, logic dat);
    case (ix)
      0: return rpt ? 12'h070 : (dat ? 12'h100 : 12'h0E0);
      1: return 12'h5C0;
      3: return 12'h200;
      default: return 12'h1E0;
    endcase
  endfunction

  // raw bit order: 0 cpu_ae, 1 dma_ae, 2 ubrk_pre, 3 irq, 4 ubrk_post
  task automatic step(input string tag, input logic v, input logic [1:0] p,
                      input logic [31:0] pc, input logic [11:0] rc,
                      input logic [4:0] raw, input logic rpt, input logic dat);
    logic [4:0] cand;
    int ix;
    logic e_acc;
    logic [2:0] e_typ;
    logic [11:0] e_code;
    logic e_rpt, e_dat;
    slot_valid_i = v; pos_i = p; pc_i = pc; rpt_cnt_i = rc;
    req_cpu_ae_i = raw[0]; req_dma_ae_i = raw[1]; req_ubrk_pre_i = raw[2];
    req_irq_i = raw[3]; req_ubrk_post_i = raw[4];
    ae_in_rpt_i = rpt; ae_is_data_i = dat;
    cand = (m_pend | raw) & elig_of(p, rc) & {5{v}};
    ix = -1;
    for (int i = 4; i >= 0; i--) if (cand[i]) ix = i;
    e_rpt = raw[0] ? rpt : m_rpt;
    e_dat = raw[0] ? dat : m_data;
    e_acc = (ix >= 0);
    e_typ = e_acc ? 3'(ix + 1) : 3'd0;
    e_code = e_acc ? code_of(ix, e_rpt, e_dat) : 12'h0;
    if (raw[0]) begin m_rpt = rpt; m_data = dat; end
    m_pend = m_pend | raw;
    if (e_acc) m_pend[ix] = 1'b0;
    @(negedge clk_i);
    n_chk++;
    if (accept_o !== e_acc ||
        (e_acc && (exc_type_o !== e_typ || evt_code_o !== e_code || saved_pc_o !== pc))) begin
      n_fail++;
      $display("FAIL %s: acc=%0b typ=%0d code=%h pc=%h exp acc=%0b typ=%0d code=%h pc=%h",
               tag, accept_o, exc_type_o, evt_code_o, saved_pc_o, e_acc, e_typ, e_code, pc);
    end
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 2'd0, 32'h0, 12'd0, 5'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: run hung");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (accept_o !== 1'b0) begin
      n_fail++; $display("FAIL R1: accept=%0b exp 0", accept_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    n_chk++;
    if (accept_o !== 1'b0) begin
      n_fail++; $display("FAIL R1: accept after reset=%0b exp 0", accept_o);
    end
    // R2 priority, R7 drain one per slot
    step("R2 all raw at ord", 1, 2'd0, 32'h100, 12'd5, 5'b11111, 1'b0, 1'b1);
    step("R7 drain dma", 1, 2'd0, 32'h104, 12'd5, 5'b0, 0, 0);
    step("R7 drain ubrk_pre", 1, 2'd3, 32'h108, 12'd5, 5'b0, 0, 0);
    step("R7 drain irq", 1, 2'd0, 32'h10C, 12'd5, 5'b0, 0, 0);
    step("R7 drain ubrk_post", 1, 2'd0, 32'h110, 12'd5, 5'b0, 0, 0);
    step("R1 nothing left", 1, 2'd0, 32'h114, 12'd5, 5'b0, 0, 0);
    // R3 near-end
    step("R3 irq blocked at near", 1, 2'd1, 32'h200, 12'd3, 5'b01000, 0, 0);
    step("R6 irq at next ord", 1, 2'd0, 32'h204, 12'd3, 5'b0, 0, 0);
    step("R3 ubrk_pre at near", 1, 2'd1, 32'h208, 12'd3, 5'b00100, 0, 0);
    step("R3 post blocked at near", 1, 2'd1, 32'h20C, 12'd3, 5'b10000, 0, 0);
    // R4 loop-end
    step("R4 post still held at end", 1, 2'd2, 32'h210, 12'd3, 5'b00100, 0, 0);
    step("R6 pre taken at near", 1, 2'd1, 32'h214, 12'd3, 5'b0, 0, 0);
    step("R6 post taken at ord", 1, 2'd0, 32'h218, 12'd3, 5'b0, 0, 0);
    step("R4 dma blocked at end", 1, 2'd2, 32'h21C, 12'd3, 5'b00010, 0, 0);
    step("R8 cpu ae rpt at end", 1, 2'd2, 32'h220, 12'd3, 5'b00001, 1, 0);
    step("R9 dma code at ord", 1, 2'd0, 32'h224, 12'd3, 5'b0, 0, 0);
    step("R8 data ae", 1, 2'd0, 32'h228, 12'd3, 5'b00001, 0, 1);
    step("R8 instr ae", 1, 2'd1, 32'h22C, 12'd3, 5'b00001, 0, 0);
    // R5 count zero
    step("R5 irq at end with rc0", 1, 2'd2, 32'h300, 12'd0, 5'b01000, 0, 0);
    step("R5 post at near with rc0", 1, 2'd1, 32'h304, 12'd0, 5'b10000, 0, 0);
    // R10 no slot
    step("R10 no slot", 0, 2'd0, 32'h400, 12'd1, 5'b00011, 1, 0);
    idle("R10 idle");
    step("R10 latched ae with rpt flag", 1, 2'd2, 32'h404, 12'd1, 5'b0, 0, 0);
    step("R9 latched dma", 1, 2'd0, 32'h408, 12'd1, 5'b0, 0, 0);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [4:0] raw;
      logic [11:0] rc;
      for (int b = 0; b < 5; b++) raw[b] = ($urandom % 8) == 0;
      rc = ($urandom % 4 == 0) ? 12'd0 : 12'($urandom);
      step("R2-random", ($urandom % 4) != 0, 2'($urandom), $urandom, rc, raw,
           1'($urandom), 1'($urandom));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule